// File: doc/BRIEF.md
# Byte-lane load/store data memory

This block is the data-side memory of a 32-bit load/store pipeline. Each request carries a base register value, a signed 16-bit displacement, a transfer size (byte, half-word or word), a store/load flag, an unsigned-load flag and store data. The block adds the displacement to the base to form a byte address. It checks that the access is naturally aligned. It then either writes the chosen byte lanes of an internal synchronous word array or reads a word and returns the selected lanes extended to 32 bits.

Storage is little-endian. The lowest-addressed byte of a datum sits in the least significant lane of a word. An access that is not a multiple of its own size is not rounded down. It raises a one-cycle fault, writes nothing and, if it was a load, returns zero. The word index wraps modulo the array depth.

Requests use a valid/ready handshake. `req_ready` is low while reset is asserted and high at all other times, so a request is accepted on any clock edge where `req_valid` and `req_ready` are both high. The block never applies back-pressure. Responses carry only a valid flag and cannot be stalled, so the consumer must take each response in the cycle it is presented.

Top module: `lsu_mem`

## Requirements
- R1: The effective address is `base` plus the sign-extended 16-bit `offset`, modulo 2^32. The word index is effective-address bits [IDX_W+1:2], so addresses beyond the depth wrap onto the array.
- R2: Little-endian lanes: the byte at effective address A occupies bits [8k+7:8k] of its word, where k = A[1:0].
- R3: `req_size` encoding: 0 = byte, 1 = half-word, 2 = word. Code 3 is illegal and is treated as a faulting access.
- R4: Alignment rules: a half-word access needs address bit 0 clear, and a word access needs address bits [1:0] clear. A violating request raises `fault` for exactly the one cycle after it is accepted.
- R5: A faulting store changes no memory byte. A faulting load still produces its response, with `rsp_data` equal to zero.
- R6: A byte load returns the selected byte sign-extended when `req_unsigned` is 0, and zero-extended when it is 1.
- R7: A half-word load returns the selected 16 bits sign-extended when `req_unsigned` is 0, and zero-extended when it is 1.
- R8: A byte store writes only `wdata[7:0]` into its lane, and a half-word store writes only `wdata[15:0]` into its two lanes. All other bytes of the word keep their values. A word store writes all four lanes.
- R9: An accepted load raises `rsp_valid` for the single cycle after acceptance, with data that reflects every store accepted before it. An accepted store produces no response.
- R10: `req_ready` is 0 during reset and 1 afterwards. When `req_valid` is 0, nothing is written, whatever the other request inputs are.
- R11: While reset is asserted, `rsp_valid` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Transfer size code (R3) |
| req_unsigned | input | 1 | Zero-extend a narrow load |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| rsp_valid | output | 1 | Load result present |
| rsp_data | output | 32 | Extended load result |
| fault | output | 1 | Alignment or size fault pulse |

## Verification
Every result is due one clock after the edge that accepts the request: a load response, its data, and the fault pulse for a load or a store. A store becomes visible to a load accepted on the very next edge. The bench applies each request just after a falling edge and predicts the outcome from a byte-array model. On the following falling edge it compares `rsp_valid`, `fault` and, when a response is due, `rsp_data` with that prediction, so every clock is checked exactly one register stage after its stimulus.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic [1:0] lane;
    xfer_size_e size;
    logic       zext;
  } load_ctl_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      base,
  input  logic [15:0]      offset,
  input  xfer_size_e       size,
  output logic [IDX_W-1:0] word_idx,
  output logic [1:0]       lane,
  output logic             misalign,
  output logic [3:0]       lane_en
);
  logic [31:0] eff_addr;

  assign eff_addr = base + {{16{offset[15]}}, offset};
  assign word_idx = eff_addr[IDX_W+1:2];
  assign lane     = eff_addr[1:0];

  always_comb begin
    misalign = 1'b0;
    lane_en  = 4'b0000;
    unique case (size)
      SZ_BYTE: lane_en = 4'b0001 << lane;
      SZ_HALF: begin
        misalign = lane[0];
        lane_en  = lane[1] ? 4'b1100 : 4'b0011;
      end
      SZ_WORD: begin
        misalign = |lane;
        lane_en  = 4'b1111;
      end
      default: misalign = 1'b1;
    endcase
    if (misalign) lane_en = 4'b0000;
  end

  // R8: only 0, 1, 2 or 4 lanes are ever enabled
  assert_lane_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_en) != 3))
    else $error("lane enable shape");

  // R5: a faulting access enables no lane
  assert_fault_no_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (lane_en == 4'b0000))
    else $error("misaligned access enables lanes");
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic [31:0] src,
  input  xfer_size_e  size,
  output logic [31:0] lane_data
);
  always_comb begin
    unique case (size)
      SZ_BYTE: lane_data = {4{src[7:0]}};
      SZ_HALF: lane_data = {2{src[15:0]}};
      default: lane_data = src;
    endcase
  end
endmodule

// File: rtl/lsu_word_ram.sv
module lsu_word_ram #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [3:0]       wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] cells [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (wr_en[g]) cells[wr_idx] <= wr_data[8*g +: 8];
      if (rd_en)    q <= cells[rd_idx];
    end

    assign rd_data[8*g +: 8] = q;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic [31:0] word,
  input  load_ctl_t   ctl,
  output logic [31:0] value
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  assign byte_sel = word[8*ctl.lane +: 8];
  assign half_sel = ctl.lane[1] ? word[31:16] : word[15:0];

  always_comb begin
    unique case (ctl.size)
      SZ_BYTE: value = {{24{byte_sel[7] & ~ctl.zext}}, byte_sel};
      SZ_HALF: value = {{16{half_sel[15] & ~ctl.zext}}, half_sel};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/lsu_mem.sv
module lsu_mem
  import lsu_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic [31:0] req_base,
  input  logic [15:0] req_offset,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        fault
);
  xfer_size_e       size_c;
  logic [IDX_W-1:0] idx_c;
  logic [1:0]       lane_c;
  logic             misalign_c;
  logic [3:0]       lane_en_c;
  logic [31:0]      st_data_c;
  logic             accept;
  logic [31:0]      rd_word;
  logic [31:0]      ld_value;
  logic             ready_q;
  logic             rsp_q;
  logic             fault_q;
  load_ctl_t        ctl_q;

  assign size_c = xfer_size_e'(req_size);
  assign accept = req_valid && ready_q;

  lsu_addr_gen #(.IDX_W(IDX_W)) u_agen (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (req_base),
    .offset   (req_offset),
    .size     (size_c),
    .word_idx (idx_c),
    .lane     (lane_c),
    .misalign (misalign_c),
    .lane_en  (lane_en_c)
  );

  lsu_store_lanes u_slanes (
    .src       (req_wdata),
    .size      (size_c),
    .lane_data (st_data_c)
  );

  lsu_word_ram #(.DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .wr_en   (lane_en_c & {4{accept && req_write}}),
    .wr_idx  (idx_c),
    .wr_data (st_data_c),
    .rd_en   (accept && !req_write),
    .rd_idx  (idx_c),
    .rd_data (rd_word)
  );

  lsu_load_extract u_lext (
    .word  (rd_word),
    .ctl   (ctl_q),
    .value (ld_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      rsp_q   <= 1'b0;
      fault_q <= 1'b0;
      ctl_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      rsp_q   <= accept && !req_write;
      fault_q <= accept && misalign_c;
      if (accept && !req_write) ctl_q <= '{lane: lane_c, size: size_c, zext: req_unsigned};
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = rsp_q;
  assign fault     = fault_q;
  assign rsp_data  = fault_q ? 32'd0 : ld_value;

  assert_load_answers_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid)
    else $error("load without response");

  assert_store_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_valid)
    else $error("store produced response");

  assert_bad_size_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_size == 2'd3) |=> fault)
    else $error("illegal size did not fault");

  assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_size == 2'd2 && (req_base[1:0] + req_offset[1:0]) != 2'd0) |=> fault)
    else $error("misaligned word not flagged");

  assert_ready_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> req_ready)
    else $error("ready dropped outside reset");
endmodule

// File: tb/lsu_mem_tb.sv
`timescale 1ns/1ps
module lsu_mem_tb_top;
  localparam int DEPTH = 256;
  localparam int BYTES = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        fault;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [BYTES];

  always #2 clk = ~clk;

  lsu_mem #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; compares on the next one.
  task automatic op(bit v, bit w, logic [1:0] sz, bit u, logic [31:0] b,
                    logic [15:0] o, logic [31:0] wd, string tag);
    logic [31:0] ea, val;
    int nb, a;
    bit bad;
    ea = b + {{16{o[15]}}, o};
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    bad = (sz == 3) || (sz == 1 && ea[0]) || (sz == 2 && ea[1:0] != 0);
    a = int'(ea % BYTES);
    val = '0;
    if (v && !bad) begin
      if (w) begin
        for (int i = 0; i < nb; i++) model[a + i] = wd[8*i +: 8];
      end else begin
        for (int i = 0; i < nb; i++) val[8*i +: 8] = model[a + i];
        if (sz == 0 && !u) val = {{24{val[7]}}, val[7:0]};
        if (sz == 1 && !u) val = {{16{val[15]}}, val[15:0]};
      end
    end
    req_valid = v; req_write = w; req_size = sz; req_unsigned = u;
    req_base = b; req_offset = o; req_wdata = wd;
    @(negedge clk);
    chk(rsp_valid == (v && !w), tag, 32'(rsp_valid), 32'(v && !w));
    chk(fault == (v && bad), tag, 32'(fault), 32'(v && bad));
    if (v && !w) chk(rsp_data === val, tag, rsp_data, val);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(rsp_valid == 0 && fault == 0, "R11", {rsp_valid, fault}, 0);
    chk(req_ready == 0, "R10", 32'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1, "R10", 32'(req_ready), 1);
    for (int i = 0; i < DEPTH; i++)
      op(1, 1, 2, 0, i * 4, 0, 32'h9E37_79B9 * (i + 1), "R1");
    op(1, 0, 2, 0, 32'h1200_4094, 16'd24, 0, "R1");
    op(1, 0, 2, 0, 32'h0000_0100, 16'hFFF8, 0, "R1");
    op(1, 1, 2, 0, 32'h0000_0400, 16'd8, 32'hCAFE_F00D, "R1");
    op(1, 0, 2, 0, 32'h0000_0008, 16'd0, 0, "R1");
    for (int k = 0; k < 4; k++)
      op(1, 1, 0, 0, 32'h40, 16'(k), 32'h1234_5600 | (32'h81 + k), "R8");
    op(1, 0, 2, 0, 32'h40, 0, 0, "R2");
    op(1, 1, 1, 0, 32'h40, 16'd2, 32'h1234_ABCD, "R8");
    op(1, 0, 2, 0, 32'h40, 0, 0, "R8");
    op(1, 0, 0, 0, 32'h40, 16'd1, 0, "R6");
    op(1, 0, 0, 1, 32'h40, 16'd1, 0, "R6");
    op(1, 0, 1, 0, 32'h42, 0, 0, "R7");
    op(1, 0, 1, 1, 32'h42, 0, 0, "R7");
    op(1, 0, 1, 0, 32'h40, 0, 0, "R7");
    op(1, 1, 2, 0, 32'h41, 0, 32'hFFFF_FFFF, "R4");
    op(1, 1, 1, 0, 32'h43, 0, 32'hFFFF_FFFF, "R4");
    op(1, 0, 2, 0, 32'h40, 0, 0, "R5");
    op(1, 0, 1, 0, 32'h43, 0, 0, "R5");
    op(1, 0, 3, 0, 32'h40, 0, 0, "R3");
    op(1, 1, 3, 0, 32'h40, 0, 32'h0, "R3");
    op(1, 0, 2, 0, 32'h40, 0, 0, "R5");
    op(0, 1, 2, 0, 32'h40, 0, 32'h0BAD_0BAD, "R10");
    op(1, 0, 2, 0, 32'h40, 0, 0, "R10");
    op(1, 1, 2, 0, 32'h80, 0, 32'h5555_AAAA, "R9");
    op(1, 0, 2, 0, 32'h80, 0, 0, "R9");
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] sz;
      logic [31:0] b;
      sz = 2'($urandom_range(0, 2));
      b = $urandom;
      if (($urandom % 8) != 0) b[1:0] = (sz == 2) ? 2'd0 : (sz == 1) ? {b[1], 1'b0} : b[1:0];
      op($urandom % 6 != 0, $urandom % 2, sz, $urandom % 2, b, 16'($urandom % 64), $urandom, "R9");
    end
    req_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4ns * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule